// File: doc/BRIEF.md
# CPU Clock Source and Power Mode Controller

This block chooses which of five oscillators drives the CPU and tracks the power state of the core: running, halted, stopped or snoozing. The five sources are a fast internal oscillator, a fast external clock or crystal, a slow subsystem clock, a PLL output and a slow internal oscillator. Software asks for a source through a control register. The controller checks whether that oscillator is on and has settled. It then commits the switch by moving a source-select output to the clock mux, and it reports the committed source one cycle later in a read-only status register.

Three guards protect each switch. A configuration register enables the external oscillator and can be written only once after reset. A stabilization counter must reach a software-chosen count before the external source is accepted. After the fast internal oscillator is restarted, a settling timer must expire before that oscillator is accepted. A request that fails a guard is refused, leaves the select and status untouched, and raises a sticky error flag.

Power requests (halt, stop, snooze, wake) move a mode state machine. Each run state has its own halt state. Stop is only possible from the two fast sources. Waking from an external-clock stop waits for the stabilization counter again.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high on a clock edge), the block is in the following state: `clk_sel` = 0, `mode` = 0, status (address 4) reads 0x20, stabilization count (address 3) reads 0, and the configuration register (address 0) reads 0.
- R2: Source codes are fast internal = 0, external = 1, subsystem = 2, PLL = 3 and slow internal = 4. The target source is decoded from control register address 1, bits [4:0] = {fast-internal-off, pll, main-external, slow-pick, sub-group}. When sub-group is 1, slow-pick chooses slow internal (1) or subsystem (0). Otherwise, when pll is 1 the target is the PLL. Otherwise main-external chooses external (1) or fast internal (0). After a control write on edge E0, `clk_sel` and the run `mode` change on edge E1. Status bits [2:0] show the new source only from edge E2 on.
- R3: Run modes use the codes 0 to 4 and are numbered like the sources. Halt modes use the codes 5 to 9, in the same order. A halt request in run mode k moves to mode k+5, and a wake event in halt mode k+5 returns to mode k.
- R4: A stop request moves fast-internal run to mode 10 and external run to mode 11. In any other run mode, a stop request leaves the mode unchanged.
- R5: In mode 10, a snooze request moves to mode 13. In mode 13, a stop request returns to mode 10. A wake event in mode 10 or mode 13 moves to mode 0.
- R6: The configuration register at address 0 has the layout [3:2] amplifier gain, [1] oscillator enable and [0] external-clock input. Only the first write after reset is accepted. Later writes leave its readback unchanged.
- R7: The stabilization count at address 3 is cleared while the oscillator enable is 0. Once the enable is 1, the count rises by one per cycle and saturates at its maximum. A switch to the external source is accepted only when the count is at least the value in address 2.
- R8: While the block is in mode 11, the stabilization count is held at 0. A wake event moves to mode 12. The block stays in mode 12 until the count reaches the address-2 value, and then returns to mode 1.
- R9: Status bit 3 is set while the committed source is the PLL. Clearing the pll control bit returns the block to the main source chosen by main-external.
- R10: When a control write changes fast-internal-off from 1 to 0, a settling timer starts. Its length is ACC_SHORT cycles when `accu_long` is 0 and ACC_LONG cycles when it is 1. The fast internal source is refused while the timer is running or while the oscillator is off. Status bit 5 shows that the fast internal source is ready.
- R11: A request for a source that is not ready leaves `clk_sel`, `mode` and status [4:0] unchanged and sets status bit 7. Bit 7 stays set until software writes 1 to bit 7 of address 4.
- R12: If a switch commits on the same edge as a halt request, the block enters the halt mode of the new source and `clk_sel` moves to the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data, combinational on bus_addr |
| accu_long | input | 1 | Option bit that selects the longer fast-internal settling interval |
| sub_ready | input | 1 | Subsystem oscillator is running |
| lso_ready | input | 1 | Slow internal oscillator is running |
| pll_lock | input | 1 | PLL is locked |
| halt_req | input | 1 | Halt request pulse |
| stop_req | input | 1 | Stop request pulse |
| wake_evt | input | 1 | Wake event pulse |
| snooze_req | input | 1 | Snooze request pulse |
| clk_sel | output | 3 | Source select driven to the clock mux |
| mode | output | 4 | Current power/run mode code |
| hio_en | output | 1 | Enable for the fast internal oscillator |
| xt_en | output | 1 | Enable for the external oscillator |
| pll_en | output | 1 | Enable for the PLL |

## Verification
A source switch and a halt request can land on the same edge. This happens when the halt pulse is driven in the cycle right after the control write, which is the cycle in which the switch is evaluated. The bench drives exactly that overlap from fast-internal run toward the subsystem source. It then expects the mode to be the subsystem halt code and the select to be the subsystem code. A later wake is expected to land in subsystem run, not in fast-internal run.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [2:0] {
        SRC_HIO = 3'd0,
        SRC_XT  = 3'd1,
        SRC_SUB = 3'd2,
        SRC_PLL = 3'd3,
        SRC_LSO = 3'd4
    } src_e;

    typedef enum logic [3:0] {
        M_RUN_HIO  = 4'd0,
        M_RUN_XT   = 4'd1,
        M_RUN_SUB  = 4'd2,
        M_RUN_PLL  = 4'd3,
        M_RUN_LSO  = 4'd4,
        M_HALT_HIO = 4'd5,
        M_HALT_XT  = 4'd6,
        M_HALT_SUB = 4'd7,
        M_HALT_PLL = 4'd8,
        M_HALT_LSO = 4'd9,
        M_STOP_HIO = 4'd10,
        M_STOP_XT  = 4'd11,
        M_WARM_XT  = 4'd12,
        M_SNOOZE   = 4'd13
    } mode_e;

    // source control register, bit 4 down to bit 0
    typedef struct packed {
        logic hio_off;
        logic pll_on;
        logic main_ext;
        logic lso_pick;
        logic sub_grp;
    } ctrl_t;

    // write-once oscillator configuration, bit 3 down to bit 0
    typedef struct packed {
        logic [1:0] amp;
        logic       osc_sel;
        logic       ext_clk;
    } cfg_t;

    localparam int unsigned ADDR_CFG   = 0;
    localparam int unsigned ADDR_CTRL  = 1;
    localparam int unsigned ADDR_STSEL = 2;
    localparam int unsigned ADDR_STCNT = 3;
    localparam int unsigned ADDR_STAT  = 4;
    localparam int unsigned ERR_BIT    = 7;

    function automatic src_e ctrl_target(input ctrl_t c);
        src_e t;
        if (c.sub_grp)     t = c.lso_pick ? SRC_LSO : SRC_SUB;
        else if (c.pll_on) t = SRC_PLL;
        else               t = c.main_ext ? SRC_XT : SRC_HIO;
        return t;
    endfunction

    function automatic mode_e run_of(input src_e s);
        mode_e m;
        case (s)
            SRC_XT:  m = M_RUN_XT;
            SRC_SUB: m = M_RUN_SUB;
            SRC_PLL: m = M_RUN_PLL;
            SRC_LSO: m = M_RUN_LSO;
            default: m = M_RUN_HIO;
        endcase
        return m;
    endfunction

    function automatic mode_e halt_of(input src_e s);
        mode_e m;
        case (s)
            SRC_XT:  m = M_HALT_XT;
            SRC_SUB: m = M_HALT_SUB;
            SRC_PLL: m = M_HALT_PLL;
            SRC_LSO: m = M_HALT_LSO;
            default: m = M_HALT_HIO;
        endcase
        return m;
    endfunction

    function automatic logic is_run(input mode_e m);
        return (m <= M_RUN_LSO);
    endfunction

endpackage

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
    import clk_mode_pkg::*;
#(
    parameter int AW     = 3,
    parameter int DW     = 8,
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [STAB_W-1:0] stab_cnt,
    input  src_e              stat_src,
    input  logic              err,
    input  logic              hio_ok,
    output cfg_t              cfg,
    output ctrl_t             ctrl,
    output logic [STAB_W-1:0] stab_sel,
    output logic              cfg_locked,
    output logic              sw_req,
    output logic              hio_restart,
    output logic              err_clr
);
    localparam int CW = $bits(ctrl_t);
    localparam int FW = $bits(cfg_t);

    logic  wr_cfg, wr_ctrl, wr_stsel, wr_stat;
    ctrl_t ctrl_new;

    always_comb begin
        wr_cfg      = bus_we && (bus_addr == AW'(ADDR_CFG));
        wr_ctrl     = bus_we && (bus_addr == AW'(ADDR_CTRL));
        wr_stsel    = bus_we && (bus_addr == AW'(ADDR_STSEL));
        wr_stat     = bus_we && (bus_addr == AW'(ADDR_STAT));
        ctrl_new    = ctrl_t'(bus_wdata[CW-1:0]);
        hio_restart = wr_ctrl && ctrl.hio_off && !ctrl_new.hio_off;
        err_clr     = wr_stat && bus_wdata[ERR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            cfg_locked <= 1'b0;
            ctrl       <= '0;
            stab_sel   <= '0;
            sw_req     <= 1'b0;
        end else begin
            if (wr_cfg && !cfg_locked) begin
                cfg        <= cfg_t'(bus_wdata[FW-1:0]);
                cfg_locked <= 1'b1;
            end
            if (wr_ctrl) ctrl <= ctrl_new;
            if (wr_stsel) stab_sel <= bus_wdata[STAB_W-1:0];
            sw_req <= wr_ctrl;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(ADDR_CFG):   bus_rdata[FW-1:0] = cfg;
            AW'(ADDR_CTRL):  bus_rdata[CW-1:0] = ctrl;
            AW'(ADDR_STSEL): bus_rdata[STAB_W-1:0] = stab_sel;
            AW'(ADDR_STCNT): bus_rdata[STAB_W-1:0] = stab_cnt;
            AW'(ADDR_STAT): begin
                bus_rdata[2:0]     = stat_src;
                bus_rdata[3]       = (stat_src == SRC_PLL);
                bus_rdata[4]       = (stat_src == SRC_SUB) || (stat_src == SRC_LSO);
                bus_rdata[5]       = hio_ok;
                bus_rdata[ERR_BIT] = err;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/clk_osc_timers.sv
module clk_osc_timers #(
    parameter int STAB_W    = 8,
    parameter int ACC_W     = 8,
    parameter int ACC_SHORT = 20,
    parameter int ACC_LONG  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_sel,
    input  logic              deep_sleep,
    input  logic [STAB_W-1:0] stab_sel,
    input  logic              hio_off,
    input  logic              hio_restart,
    input  logic              accu_long,
    output logic [STAB_W-1:0] stab_cnt,
    output logic              xt_ok,
    output logic              hio_ok
);
    localparam logic [STAB_W-1:0] CNT_MAX = '1;
    localparam logic [ACC_W-1:0]  LOAD_S  = ACC_W'(ACC_SHORT);
    localparam logic [ACC_W-1:0]  LOAD_L  = ACC_W'(ACC_LONG);

    logic             run_en;
    logic [ACC_W-1:0] acc_q;

    assign run_en = osc_sel && !deep_sleep;

    always_ff @(posedge clk) begin
        if (rst || !run_en)          stab_cnt <= '0;
        else if (stab_cnt != CNT_MAX) stab_cnt <= stab_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)               acc_q <= '0;
        else if (hio_restart)  acc_q <= accu_long ? LOAD_L : LOAD_S;
        else if (acc_q != '0)  acc_q <= acc_q - 1'b1;
    end

    assign xt_ok  = osc_sel && (stab_cnt >= stab_sel);
    assign hio_ok = !hio_off && (acc_q == '0);
endmodule

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
    import clk_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sw_req,
    input  src_e  target,
    input  logic  hio_ok,
    input  logic  xt_ok,
    input  logic  sub_ok,
    input  logic  lso_ok,
    input  logic  pll_ok,
    input  logic  halt_req,
    input  logic  stop_req,
    input  logic  wake_evt,
    input  logic  snooze_req,
    input  logic  err_clr,
    output mode_e state_q,
    output src_e  sel_q,
    output src_e  stat_q,
    output logic  err_q,
    output logic  deep_sleep
);
    logic  tgt_ok, want, commit, reject;
    src_e  nsrc;
    mode_e state_d;

    always_comb begin
        case (target)
            SRC_HIO: tgt_ok = hio_ok;
            SRC_XT:  tgt_ok = xt_ok;
            SRC_SUB: tgt_ok = sub_ok;
            SRC_PLL: tgt_ok = pll_ok;
            SRC_LSO: tgt_ok = lso_ok;
            default: tgt_ok = 1'b0;
        endcase
        want   = is_run(state_q) && sw_req && (target != sel_q);
        commit = want && tgt_ok;
        reject = want && !tgt_ok;
        nsrc   = commit ? target : sel_q;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            M_RUN_HIO, M_RUN_XT, M_RUN_SUB, M_RUN_PLL, M_RUN_LSO: begin
                if (halt_req)                           state_d = halt_of(nsrc);
                else if (stop_req && nsrc == SRC_HIO)   state_d = M_STOP_HIO;
                else if (stop_req && nsrc == SRC_XT)    state_d = M_STOP_XT;
                else                                    state_d = run_of(nsrc);
            end
            M_HALT_HIO: if (wake_evt) state_d = M_RUN_HIO;
            M_HALT_XT:  if (wake_evt) state_d = M_RUN_XT;
            M_HALT_SUB: if (wake_evt) state_d = M_RUN_SUB;
            M_HALT_PLL: if (wake_evt) state_d = M_RUN_PLL;
            M_HALT_LSO: if (wake_evt) state_d = M_RUN_LSO;
            M_STOP_HIO: begin
                if (wake_evt)        state_d = M_RUN_HIO;
                else if (snooze_req) state_d = M_SNOOZE;
            end
            M_SNOOZE: begin
                if (wake_evt)      state_d = M_RUN_HIO;
                else if (stop_req) state_d = M_STOP_HIO;
            end
            M_STOP_XT: if (wake_evt) state_d = M_WARM_XT;
            M_WARM_XT: if (xt_ok)    state_d = M_RUN_XT;
            default:   state_d = M_RUN_HIO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M_RUN_HIO;
            sel_q   <= SRC_HIO;
            stat_q  <= SRC_HIO;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= nsrc;
            stat_q  <= sel_q;
            if (reject)       err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end

    assign deep_sleep = (state_q == M_STOP_HIO) || (state_q == M_STOP_XT) ||
                        (state_q == M_SNOOZE);
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int AW        = 3,
    parameter int DW        = 8,
    parameter int STAB_W    = 8,
    parameter int ACC_W     = 8,
    parameter int ACC_SHORT = 20,
    parameter int ACC_LONG  = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          accu_long,
    input  logic          sub_ready,
    input  logic          lso_ready,
    input  logic          pll_lock,
    input  logic          halt_req,
    input  logic          stop_req,
    input  logic          wake_evt,
    input  logic          snooze_req,
    output logic [2:0]    clk_sel,
    output logic [3:0]    mode,
    output logic          hio_en,
    output logic          xt_en,
    output logic          pll_en
);
    cfg_t              cfg;
    ctrl_t             ctrl;
    logic [STAB_W-1:0] stab_sel, stab_cnt;
    logic              cfg_locked, sw_req, hio_restart, err_clr;
    logic              xt_ok, hio_ok, err_q, deep_sleep;
    mode_e             state_q;
    src_e              sel_q, stat_src;
    logic [3:0]        cfg_q;

    clk_mode_regs #(.AW(AW), .DW(DW), .STAB_W(STAB_W)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stab_cnt(stab_cnt),
        .stat_src(stat_src), .err(err_q), .hio_ok(hio_ok), .cfg(cfg),
        .ctrl(ctrl), .stab_sel(stab_sel), .cfg_locked(cfg_locked),
        .sw_req(sw_req), .hio_restart(hio_restart), .err_clr(err_clr)
    );

    clk_osc_timers #(.STAB_W(STAB_W), .ACC_W(ACC_W), .ACC_SHORT(ACC_SHORT),
                     .ACC_LONG(ACC_LONG)) u_timers (
        .clk(clk), .rst(rst), .osc_sel(cfg.osc_sel), .deep_sleep(deep_sleep),
        .stab_sel(stab_sel), .hio_off(ctrl.hio_off), .hio_restart(hio_restart),
        .accu_long(accu_long), .stab_cnt(stab_cnt), .xt_ok(xt_ok), .hio_ok(hio_ok)
    );

    clk_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .sw_req(sw_req), .target(ctrl_target(ctrl)),
        .hio_ok(hio_ok), .xt_ok(xt_ok), .sub_ok(sub_ready), .lso_ok(lso_ready),
        .pll_ok(pll_lock), .halt_req(halt_req), .stop_req(stop_req),
        .wake_evt(wake_evt), .snooze_req(snooze_req), .err_clr(err_clr),
        .state_q(state_q), .sel_q(sel_q), .stat_q(stat_src), .err_q(err_q),
        .deep_sleep(deep_sleep)
    );

    assign cfg_q   = cfg;
    assign clk_sel = sel_q;
    assign mode    = state_q;
    assign hio_en  = !ctrl.hio_off;
    assign xt_en   = cfg.osc_sel && !deep_sleep;
    assign pll_en  = ctrl.pll_on;
endmodule

// File: rtl/clk_mode_checker.sv
module clk_mode_checker #(
    parameter int STAB_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        clk_sel,
    input logic [2:0]        stat_src,
    input logic [3:0]        mode,
    input logic              sw_req,
    input logic              cfg_locked,
    input logic [3:0]        cfg_q,
    input logic [STAB_W-1:0] stab_cnt,
    input logic [STAB_W-1:0] stab_sel,
    input logic              hio_ok,
    input logic              err
);
    assert_sel_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_sel) |-> $past(sw_req));

    assert_status_lags_select_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_sel) |-> $stable(stat_src));

    assert_halt_returns_home_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) >= 4'd5 && $past(mode) <= 4'd9 && mode != $past(mode))
        |-> (mode == $past(mode) - 4'd5));

    assert_stop_int_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd10 && $past(mode) != 4'd10)
        |-> ($past(mode) == 4'd0 || $past(mode) == 4'd13));

    assert_stop_ext_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd11 && $past(mode) != 4'd11) |-> ($past(mode) == 4'd1));

    assert_cfg_write_once_R6: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_locked) |-> $stable(cfg_q));

    assert_ext_needs_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'd1 && $past(clk_sel) != 3'd1) |-> ($past(stab_cnt) >= $past(stab_sel)));

    assert_stop_holds_count_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd11 && $past(mode) == 4'd11) |-> (stab_cnt == '0));

    assert_int_needs_settle_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'd0 && $past(clk_sel) != 3'd0) |-> $past(hio_ok));

    assert_reject_keeps_sel_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $stable(clk_sel));
endmodule

bind clk_mode_ctrl clk_mode_checker #(.STAB_W(STAB_W)) u_chk (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .stat_src(stat_src), .mode(mode),
    .sw_req(sw_req), .cfg_locked(cfg_locked), .cfg_q(cfg_q), .stab_cnt(stab_cnt),
    .stab_sel(stab_sel), .hio_ok(hio_ok), .err(err_q)
);

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       accu_long = 1'b0;
    logic       sub_ready = 1'b1, lso_ready = 1'b1, pll_lock = 1'b1;
    logic       halt_req = 1'b0, stop_req = 1'b0, wake_evt = 1'b0, snooze_req = 1'b0;
    logic [2:0] clk_sel;
    logic [3:0] mode;
    logic       hio_en, xt_en, pll_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    kind;   // 0 select, 1 mode, 2 read data
        int    val;
    } item_t;

    item_t exp_q[$];
    item_t cur;

    always #5 clk = ~clk;

    clk_mode_ctrl u_clk_mode_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .accu_long(accu_long),
        .sub_ready(sub_ready), .lso_ready(lso_ready), .pll_lock(pll_lock),
        .halt_req(halt_req), .stop_req(stop_req), .wake_evt(wake_evt),
        .snooze_req(snooze_req), .clk_sel(clk_sel), .mode(mode),
        .hio_en(hio_en), .xt_en(xt_en), .pll_en(pll_en)
    );

    // monitor: compares queued expectations just after each rising edge
    always @(posedge clk) begin
        #3;
        while (exp_q.size() > 0) begin
            int act;
            cur = exp_q.pop_front();
            act = (cur.kind == 0) ? int'(clk_sel) :
                  (cur.kind == 1) ? int'(mode) : int'(bus_rdata);
            checks++;
            if (act != cur.val) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", cur.tag, cur.kind, act, cur.val);
            end
        end
    end

    task automatic expect_item(input string tag, input int kind, input int val);
        item_t it;
        it.tag = tag; it.kind = kind; it.val = val;
        exp_q.push_back(it);
    endtask

    task automatic expect_run(input string tag, input int sel, input int m);
        expect_item(tag, 0, sel);
        expect_item(tag, 1, m);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(input string tag, input int a, input int v);
        bus_addr = 3'(a);
        expect_item(tag, 2, v);
        @(negedge clk);
    endtask

    task automatic do_halt();   halt_req = 1'b1;   @(negedge clk); halt_req = 1'b0;   endtask
    task automatic do_stop();   stop_req = 1'b1;   @(negedge clk); stop_req = 1'b0;   endtask
    task automatic do_wake();   wake_evt = 1'b1;   @(negedge clk); wake_evt = 1'b0;   endtask
    task automatic do_snooze(); snooze_req = 1'b1; @(negedge clk); snooze_req = 1'b0; endtask

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        expect_run("R1 reset", 0, 0);
        rd_exp("R1 reset status", 4, 8'h20);
        rd_exp("R1 reset count", 3, 0);
        rd_exp("R1 reset config", 0, 0);

        // R2 switch to subsystem, status lags by one cycle
        wr(1, 8'h01);
        expect_run("R2 commit sub", 2, 2);
        rd_exp("R2 status before update", 4, 8'h20);
        rd_exp("R2 status after update", 4, 8'h32);

        // R3 halt and wake from subsystem
        do_halt();
        expect_run("R3 halt sub", 2, 7);
        tick(1);
        do_wake();
        expect_item("R3 wake sub", 1, 2);
        tick(1);

        // R4 stop ignored while on subsystem
        do_stop();
        expect_item("R4 stop ignored on sub", 1, 2);
        tick(1);

        // R2 slow internal, R3 its halt
        wr(1, 8'h03);
        expect_run("R2 commit slow", 4, 4);
        tick(1);
        do_halt();
        expect_item("R3 halt slow", 1, 9);
        tick(1);
        do_wake();
        expect_item("R3 wake slow", 1, 4);
        tick(1);

        wr(1, 8'h00);
        expect_run("R2 back to fast internal", 0, 0);
        tick(1);
        do_halt();
        expect_item("R3 halt fast", 1, 5);
        tick(1);
        do_wake();
        expect_item("R3 wake fast", 1, 0);
        tick(1);

        // R6 write-once configuration
        wr(2, 200);
        wr(0, 8'h02);
        rd_exp("R6 first config write", 0, 8'h02);
        wr(0, 8'h05);
        rd_exp("R6 second config write ignored", 0, 8'h02);

        // R11 and R7: external not yet stable -> refused
        wr(1, 8'h04);
        expect_run("R11 refused external keeps select", 0, 0);
        rd_exp("R11 error flag set", 4, 8'hA0);
        rd_exp("R11 status source unchanged", 4, 8'hA0);
        wr(4, 8'h80);
        rd_exp("R11 error cleared", 4, 8'h20);

        // R7 count saturates, then external accepted
        tick(260);
        rd_exp("R7 count saturates", 3, 255);
        wr(1, 8'h04);
        expect_run("R7 external accepted", 1, 1);
        tick(1);
        rd_exp("R7 status external", 4, 8'h21);

        // R9 PLL select and release
        wr(1, 8'h0C);
        expect_run("R9 pll commit", 3, 3);
        rd_exp("R9 status before update", 4, 8'h21);
        rd_exp("R9 pll status bit", 4, 8'h2B);
        do_halt();
        expect_item("R3 halt pll", 1, 8);
        tick(1);
        do_wake();
        expect_item("R3 wake pll", 1, 3);
        tick(1);
        wr(1, 8'h04);
        expect_run("R9 pll release to external", 1, 1);
        tick(1);
        do_halt();
        expect_item("R3 halt external", 1, 6);
        tick(1);
        do_wake();
        expect_item("R3 wake external", 1, 1);
        tick(1);

        // R8 stop from external, warm-up on wake
        wr(2, 10);
        do_stop();
        expect_run("R4 stop from external", 1, 11);
        tick(2);
        rd_exp("R8 count held in stop", 3, 0);
        do_wake();
        expect_item("R8 warm after wake", 1, 12);
        tick(9);
        expect_item("R8 still warming", 1, 12);
        tick(1);
        expect_item("R8 back to external run", 1, 1);
        tick(1);

        wr(1, 8'h00);
        expect_run("R2 external to fast internal", 0, 0);
        tick(1);

        // R12 switch and halt in the same cycle
        bus_we = 1'b1; bus_addr = 3'(1); bus_wdata = 8'h01;
        @(negedge clk);
        bus_we = 1'b0; halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        expect_run("R12 halt of new source", 2, 7);
        tick(1);
        do_wake();
        expect_item("R12 wake into new source", 1, 2);
        tick(1);

        // R10 short settling interval
        wr(1, 8'h11);
        tick(1);
        rd_exp("R10 fast internal off", 4, 8'h12);
        wr(1, 8'h01);
        wr(1, 8'h00);
        expect_run("R10 refused while settling short", 2, 2);
        rd_exp("R11 error on settling refusal", 4, 8'h92);
        wr(4, 8'h80);
        tick(25);
        wr(1, 8'h00);
        expect_run("R10 accepted after short interval", 0, 0);
        tick(1);

        // R10 long settling interval
        accu_long = 1'b1;
        wr(1, 8'h11);
        expect_run("R2 to sub before long test", 2, 2);
        wr(1, 8'h01);
        tick(25);
        wr(1, 8'h00);
        expect_run("R10 refused within long interval", 2, 2);
        rd_exp("R10 long refusal status", 4, 8'h92);
        wr(4, 8'h80);
        tick(20);
        wr(1, 8'h00);
        expect_run("R10 accepted after long interval", 0, 0);
        tick(1);

        // R5 stop, snooze and wake
        do_stop();
        expect_item("R5 stop from fast internal", 1, 10);
        tick(1);
        do_snooze();
        expect_item("R5 snooze", 1, 13);
        tick(1);
        do_stop();
        expect_item("R5 back to stop", 1, 10);
        tick(1);
        do_snooze();
        expect_item("R5 snooze again", 1, 13);
        tick(1);
        do_wake();
        expect_run("R5 wake from snooze", 0, 0);
        tick(1);
        do_stop();
        tick(1);
        do_wake();
        expect_item("R5 wake from stop", 1, 0);
        tick(2);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule